// File: doc/BRIEF.md
# Fingerprint Frame Capture Sequencer

This block turns a one-byte command on a serial receive stream into a single fingerprint image transfer. While idle it looks at every byte the receive side offers and acts only on the start command, the ASCII letter `G` (0x47). On that byte it takes the SPI master role toward the sensor and pulls one image of `FRAME_BYTES` bytes, 30400 by default, one byte at a time.

Each byte that arrives from the sensor goes two places in the same step. It is written to an external parallel SRAM at an address that counts up from zero. It is also offered to the serial transmitter through a valid/ready handshake. The next sensor byte is not requested until the transmitter has taken the current one, so a slow link stalls the capture and no byte is dropped. After the last byte has been accepted, the block returns to standby and raises a one-cycle done pulse.

A separate result input, written by the matching host, sets a small LED register that shows either a match or a reject. The register keeps its value until the next result arrives.

Top module: `capture_seq`

## Requirements
- R1: During and straight after reset, `busy`, `done`, `spi_start`, `tx_valid`, `led_match` and `led_reject` are low and `sram_we_n` is high.
- R2: While idle, a received byte other than 0x47 does nothing: `busy` stays low and no `spi_start` is issued.
- R3: A received 0x47 while idle starts a capture: from the next cycle `busy` is high and `spi_start` is pulsed to request the first sensor byte.
- R4: Every sensor byte is written to SRAM with `sram_we_n` low for exactly one cycle. The address is 0 for the first byte of a capture and rises by one for each later byte, and the data is the byte the sensor returned.
- R5: Every sensor byte is offered on `tx_data` in sensor order. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R6: No `spi_start` is issued while a byte is waiting for the transmitter to accept it.
- R7: A capture moves exactly `FRAME_BYTES` bytes (30400 by default). The cycle after the last byte is accepted, `busy` is low and `done` is high for that one cycle only.
- R8: A 0x47 received while a capture is running is ignored: the address sequence does not restart, and no second capture follows.
- R9: When `result_valid` is high, `led_match` takes `result_match` and `led_reject` takes its inverse on the next cycle. Without `result_valid` both LEDs hold their values, including across captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present on rx_data this cycle |
| rx_data | input | 8 | Received command byte |
| spi_start | output | 1 | One-cycle request to the SPI master to read one sensor byte |
| spi_done | input | 1 | The requested sensor byte is on spi_rdata |
| spi_rdata | input | 8 | Byte read from the sensor |
| sram_addr | output | 15 | SRAM write address |
| sram_wdata | output | 8 | SRAM write data |
| sram_we_n | output | 1 | SRAM write strobe, active low, one cycle per byte |
| tx_valid | output | 1 | A byte is offered to the serial transmitter |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| result_valid | input | 1 | Load the LED register this cycle |
| result_match | input | 1 | 1 = match, 0 = reject |
| led_match | output | 1 | Match indicator |
| led_reject | output | 1 | Reject indicator |
| busy | output | 1 | A capture is in progress |
| done | output | 1 | One-cycle pulse on return to idle |

## Verification
The bench runs one full-length capture while the transmitter refuses two cycles out of every seven. A design that did not hold its offer, or that requested the next sensor byte early, would lose or reorder bytes, and the stream would stop matching the sensor pattern. It checks the first and last addresses and the exact byte total, which catch an off-by-one end condition and an address that does not start at zero. A second `G` is sent midway through; a design that restarted would write address 0 again or run a second capture after `done`. Non-command bytes sent while idle, and result bits toggled without `result_valid`, show whether the design wrongly starts a capture or lets the LEDs follow the input directly.

// File: rtl/capture_seq.sv
module capture_seq #(
  parameter int              FRAME_BYTES = 30400,
  parameter int              DW          = 8,
  parameter int              AW          = $clog2(FRAME_BYTES),
  parameter logic [DW-1:0]   START_CMD   = 8'h47
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          spi_start,
  input  logic          spi_done,
  input  logic [DW-1:0] spi_rdata,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_wdata,
  output logic          sram_we_n,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          result_valid,
  input  logic          result_match,
  output logic          led_match,
  output logic          led_reject,
  output logic          busy,
  output logic          done
);

  localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_PUSH, S_HOLD} state_t;

  state_t        state;
  logic [AW-1:0] idx;
  logic [DW-1:0] pix;

  assign busy       = (state != S_IDLE);
  assign spi_start  = (state == S_REQ);
  assign sram_we_n  = (state != S_PUSH);
  assign tx_valid   = (state == S_PUSH) || (state == S_HOLD);
  assign sram_addr  = idx;
  assign sram_wdata = pix;
  assign tx_data    = pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      pix   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE:
          if (rx_valid && rx_data == START_CMD) begin
            idx   <= '0;
            state <= S_REQ;
          end
        S_REQ:
          state <= S_WAIT;
        S_WAIT:
          if (spi_done) begin
            pix   <= spi_rdata;
            state <= S_PUSH;
          end
        S_PUSH, S_HOLD:
          if (tx_ready) begin
            if (idx == LAST_IDX) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_REQ;
            end
          end else begin
            state <= S_HOLD;
          end
        default:
          state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_match  <= 1'b0;
      led_reject <= 1'b0;
    end else if (result_valid) begin
      led_match  <= result_match;
      led_reject <= !result_match;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && sram_we_n && !tx_valid && !led_match && !led_reject));

  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rx_valid && rx_data == START_CMD) |=> (busy && spi_start));

  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n);

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r6_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !tx_valid);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !$past(done)));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_valid && !(tx_valid && tx_ready)) |=> busy);

  a_r9_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |=> $stable({led_match, led_reject}));

  a_r9_led_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({led_match, led_reject}));

endmodule

// File: tb/capture_seq_test.sv
`timescale 1ns/1ps
module capture_seq_test;

  localparam int FRAME = 30400;
  localparam int AW    = $clog2(FRAME);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = 8'h00;
  logic          spi_start;
  logic          spi_done = 1'b0;
  logic [7:0]    spi_rdata = 8'h00;
  logic [AW-1:0] sram_addr;
  logic [7:0]    sram_wdata;
  logic          sram_we_n;
  logic          tx_valid;
  logic [7:0]    tx_data;
  logic          tx_ready = 1'b0;
  logic          result_valid = 1'b0;
  logic          result_match = 1'b0;
  logic          led_match, led_reject, busy, done;

  int n_checks = 0, n_fail = 0;

  int cyc = 0, sens_idx = 0, wr_n = 0, tx_n = 0, req_n = 0, done_n = 0;
  int first_addr = -1, last_addr = -1;
  int err_wr = 0, err_tx = 0, err_hold = 0, err_early = 0, err_busy = 0, err_done = 0;
  bit pend = 0, stalled = 0;
  logic [7:0] stall_data = 8'h00;

  capture_seq #(.FRAME_BYTES(FRAME)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .spi_start(spi_start), .spi_done(spi_done), .spi_rdata(spi_rdata),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we_n(sram_we_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .result_valid(result_valid), .result_match(result_match),
    .led_match(led_match), .led_reject(led_reject), .busy(busy), .done(done));

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int n);
    return 8'((n * 13) ^ (n >> 7));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sensor, transmitter and monitor share one loop so drive and sample never race
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = !((cyc % 7) == 3 || (cyc % 7) == 4);
      spi_done = 1'b0;
      if (pend) begin
        spi_done  = 1'b1;
        spi_rdata = pat(sens_idx);
        sens_idx++;
        pend = 0;
      end
      if (rst_n) begin
        if (spi_start) begin
          pend = 1;
          req_n++;
          if (wr_n != tx_n) err_early++;
        end
        if (stalled && (!tx_valid || tx_data != stall_data)) err_hold++;
        stalled = 0;
        if (!sram_we_n) begin
          if (sram_addr != AW'(wr_n) || sram_wdata != pat(wr_n)) err_wr++;
          if (!busy) err_busy++;
          if (first_addr < 0) first_addr = int'(sram_addr);
          last_addr = int'(sram_addr);
          wr_n++;
        end
        if (tx_valid) begin
          if (tx_ready) begin
            if (tx_data != pat(tx_n)) err_tx++;
            tx_n++;
          end else begin
            stalled = 1;
            stall_data = tx_data;
          end
        end
        if (done) begin
          done_n++;
          if (busy) err_done++;
        end
      end
    end
  end

  task automatic send_rx(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic load_result(bit m);
    @(negedge clk);
    result_valid = 1'b1;
    result_match = m;
    @(negedge clk);
    result_valid = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && sram_we_n && !tx_valid && !spi_start, "R1", "outputs in reset",
          {busy, done, sram_we_n, tx_valid, spi_start}, 5'b00100);
    check(!led_match && !led_reject, "R1", "leds in reset", {led_match, led_reject}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && sram_we_n && !tx_valid, "R1", "outputs after release",
          {busy, sram_we_n, tx_valid}, 3'b010);
  endtask

  task automatic test_ignore_idle();
    int r0 = req_n;
    send_rx(8'h67);
    send_rx(8'h46);
    send_rx(8'h48);
    send_rx(8'h00);
    repeat (4) @(negedge clk);
    check(!busy, "R2", "busy after non-command bytes", busy, 0);
    check(req_n == r0, "R2", "sensor requests after non-command bytes", req_n - r0, 0);
  endtask

  task automatic test_leds();
    load_result(1'b1);
    check(led_match && !led_reject, "R9", "match loaded", {led_match, led_reject}, 2'b10);
    @(negedge clk);
    result_match = 1'b0;
    repeat (3) @(negedge clk);
    check(led_match && !led_reject, "R9", "no load without valid", {led_match, led_reject}, 2'b10);
    load_result(1'b0);
    check(!led_match && led_reject, "R9", "reject loaded", {led_match, led_reject}, 2'b01);
    load_result(1'b1);
    check(led_match && !led_reject, "R9", "match reloaded", {led_match, led_reject}, 2'b10);
  endtask

  task automatic test_capture();
    int guard = 0;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = 8'h47;
    @(negedge clk);
    rx_valid = 1'b0;
    check(busy && spi_start, "R3", "busy and request after command", {busy, spi_start}, 2'b11);
    while (wr_n < 1000 && guard < 20000) begin @(negedge clk); guard++; end
    send_rx(8'h47);
    guard = 0;
    while (done_n == 0 && guard < 150000) begin @(negedge clk); guard++; end
    check(done_n == 1, "R7", "done pulses at end", done_n, 1);
    check(!busy, "R7", "busy low with done", busy, 0);
    @(negedge clk);
    check(!done, "R7", "done lasts one cycle", done, 0);
    check(wr_n == FRAME, "R7", "bytes written", wr_n, FRAME);
    check(tx_n == FRAME, "R7", "bytes transmitted", tx_n, FRAME);
    check(first_addr == 0, "R4", "first address", first_addr, 0);
    check(last_addr == FRAME - 1, "R4", "last address", last_addr, FRAME - 1);
    check(err_wr == 0, "R4", "address/data mismatches", err_wr, 0);
    check(err_busy == 0, "R4", "writes while not busy", err_busy, 0);
    check(err_tx == 0, "R5", "transmit order mismatches", err_tx, 0);
    check(err_hold == 0, "R5", "offer dropped or changed while stalled", err_hold, 0);
    check(err_early == 0, "R6", "requests with byte pending", err_early, 0);
    check(err_done == 0, "R7", "done while busy", err_done, 0);
    repeat (30) @(negedge clk);
    check(!busy && wr_n == FRAME, "R8", "no second capture after mid-run command", wr_n, FRAME);
    check(done_n == 1, "R8", "single done after mid-run command", done_n, 1);
    check(led_match && !led_reject, "R9", "leds held across capture", {led_match, led_reject}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    test_reset();
    test_ignore_idle();
    test_leds();
    test_capture();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule